// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block collects 32 level-sensitive interrupt sources and presents them to a processor as two request lines: a fast line and a normal line. A simple 32-bit register bus (enable, write flag, 12-bit byte address, write data, combinational read data) programs it. Each source carries an enable bit, a software-raise bit and a routing bit that picks the fast or the normal line. Enables and software bits each have a pair of write ports, one that sets and one that clears, so that a single source can be changed without a read-modify-write.

Sixteen vector slots map a source number to a handler address. Slot 0 has the highest priority. When software reads the current-vector register, it receives the address of the winning slot, or a default address when no slot matches, and that priority level enters service. While a level is in service, only strictly higher-priority slots can raise the normal line again. A write of any value to the same register ends the most urgent level in service. A fixed identification word can be read one byte at a time.

Top module: `vec_intc`

## Requirements
- R1: After reset every enable, routing and software bit is 0, every slot is disabled, the default address is 0, no level is in service, both request lines are low and the current-vector register (0x030) reads 0.
- R2: The raw status at 0x008 reads the hardware inputs ORed with the software bits, with no masking. Writes to the status addresses 0x000, 0x004 and 0x008 change nothing.
- R3: A 1 written to bit n at 0x010 enables source n, and a 1 at 0x014 disables it. Bits written as 0 keep their value. Reading 0x010 returns the enable mask.
- R4: A 1 written to bit n at 0x018 raises software interrupt n, and a 1 at 0x01C lowers it. Bits written as 0 keep their value. Reading 0x018 returns the software mask.
- R5: At 0x00C, a routing bit of 1 sends its source to the fast line and 0 sends it to the normal line. 0x000 reads raw AND enable AND NOT routing. 0x004 reads raw AND enable AND routing.
- R6: The fast line is high exactly when 0x004 is non-zero. With no level in service, the normal line is high exactly when 0x000 is non-zero.
- R7: The control word of slot n is at 0x200+4n, with bit 5 as enable and bits 4:0 as source number. Its address is at 0x100+4n. Reading 0x030 returns the address of the lowest-numbered enabled slot whose source is set in 0x000. If none qualifies, it returns the default address held at 0x034.
- R8: A read of 0x030 puts the returned slot's level into service. If it returns the default address while nothing is in service and 0x000 is non-zero, it puts the lowest level into service. While levels are in service, only slots numbered below the most urgent level in service drive the normal line or win the vector read.
- R9: A write of any value to 0x030 ends exactly one level in service: the most urgent one.
- R10: With all enables cleared, one write of 0 to 0x030 followed by 19 read-then-write pairs on 0x030 leaves no level in service, starting from any depth.
- R11: Bytes 0 to 3 of the identification word read in bits 7:0 at 0xFE0, 0xFE4, 0xFE8 and 0xFEC. The vendor code is bits 19:12 of the assembled word.
- R12: Slot addresses, slot control words (6 bits), the default address and the protection bit (bit 0 at 0x020) read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| src_in | input | NSRC | Level-sensitive hardware interrupt inputs |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The properties assume the bus issues at most one access per cycle and that the source inputs are synchronous to the clock. The nesting properties also assume that a push and a pop never happen in the same cycle, which the single read/write flag guarantees. The bench changes source levels and bus signals only on the falling edge, one access per cycle. It counts push depth by driving sources in a fixed order, so that each vector read enters a strictly more urgent level. The unwinding sequence runs only after all enables are cleared, the condition under which the block bounds the number of pairs.

// File: rtl/vec_intc_pkg.sv
package vec_intc_pkg;

   localparam int BUS_AW = 12;
   localparam int BUS_DW = 32;

   localparam logic [BUS_AW-1:0] OFS_IRQ_STAT = 12'h000;
   localparam logic [BUS_AW-1:0] OFS_FIQ_STAT = 12'h004;
   localparam logic [BUS_AW-1:0] OFS_RAW_STAT = 12'h008;
   localparam logic [BUS_AW-1:0] OFS_ROUTE    = 12'h00C;
   localparam logic [BUS_AW-1:0] OFS_EN_SET   = 12'h010;
   localparam logic [BUS_AW-1:0] OFS_EN_CLR   = 12'h014;
   localparam logic [BUS_AW-1:0] OFS_SW_SET   = 12'h018;
   localparam logic [BUS_AW-1:0] OFS_SW_CLR   = 12'h01C;
   localparam logic [BUS_AW-1:0] OFS_PROT     = 12'h020;
   localparam logic [BUS_AW-1:0] OFS_CUR_VEC  = 12'h030;
   localparam logic [BUS_AW-1:0] OFS_DEF_VEC  = 12'h034;
   localparam logic [3:0]        PAGE_VADDR   = 4'h1;
   localparam logic [3:0]        PAGE_VCTRL   = 4'h2;
   localparam logic [7:0]        ID_ROW       = 8'hFE;

   typedef enum logic [3:0] {
      RS_NONE,
      RS_IRQ_STAT,
      RS_FIQ_STAT,
      RS_RAW_STAT,
      RS_ROUTE,
      RS_EN_SET,
      RS_EN_CLR,
      RS_SW_SET,
      RS_SW_CLR,
      RS_PROT,
      RS_CUR_VEC,
      RS_DEF_VEC,
      RS_VADDR,
      RS_VCTRL,
      RS_ID
   } reg_sel_e;

   function automatic reg_sel_e decode_reg(input logic [BUS_AW-1:0] a);
      reg_sel_e r;
      r = RS_NONE;
      case (a)
         OFS_IRQ_STAT: r = RS_IRQ_STAT;
         OFS_FIQ_STAT: r = RS_FIQ_STAT;
         OFS_RAW_STAT: r = RS_RAW_STAT;
         OFS_ROUTE:    r = RS_ROUTE;
         OFS_EN_SET:   r = RS_EN_SET;
         OFS_EN_CLR:   r = RS_EN_CLR;
         OFS_SW_SET:   r = RS_SW_SET;
         OFS_SW_CLR:   r = RS_SW_CLR;
         OFS_PROT:     r = RS_PROT;
         OFS_CUR_VEC:  r = RS_CUR_VEC;
         OFS_DEF_VEC:  r = RS_DEF_VEC;
         default: begin
            if (a[1:0] == 2'b00) begin
               if (a[11:8] == PAGE_VADDR)      r = RS_VADDR;
               else if (a[11:8] == PAGE_VCTRL) r = RS_VCTRL;
               else if (a[11:4] == ID_ROW)     r = RS_ID;
            end
         end
      endcase
      return r;
   endfunction

endpackage

// File: rtl/vec_intc_srcregs.sv
module vec_intc_srcregs
   import vec_intc_pkg::*;
#(
   parameter int NSRC = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  reg_sel_e        rsel,
   input  logic [NSRC-1:0] wdata,
   input  logic            prot_wbit,
   input  logic [NSRC-1:0] src_in,
   output logic [NSRC-1:0] en_q,
   output logic [NSRC-1:0] sel_q,
   output logic [NSRC-1:0] soft_q,
   output logic            prot_q,
   output logic [NSRC-1:0] raw,
   output logic [NSRC-1:0] irq_stat,
   output logic [NSRC-1:0] fiq_stat
);

   logic en_set_w, en_clr_w, sw_set_w, sw_clr_w, route_w;

   assign en_set_w = wr_en && (rsel == RS_EN_SET);
   assign en_clr_w = wr_en && (rsel == RS_EN_CLR);
   assign sw_set_w = wr_en && (rsel == RS_SW_SET);
   assign sw_clr_w = wr_en && (rsel == RS_SW_CLR);
   assign route_w  = wr_en && (rsel == RS_ROUTE);

   // one set/clear cell per source for the enable and software masks
   for (genvar gi = 0; gi < NSRC; gi++) begin : g_src
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            en_q[gi]   <= 1'b0;
            soft_q[gi] <= 1'b0;
            sel_q[gi]  <= 1'b0;
         end else begin
            if (en_set_w && wdata[gi])      en_q[gi] <= 1'b1;
            else if (en_clr_w && wdata[gi]) en_q[gi] <= 1'b0;
            if (sw_set_w && wdata[gi])      soft_q[gi] <= 1'b1;
            else if (sw_clr_w && wdata[gi]) soft_q[gi] <= 1'b0;
            if (route_w)                    sel_q[gi] <= wdata[gi];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               prot_q <= 1'b0;
      else if (wr_en && (rsel == RS_PROT))      prot_q <= prot_wbit;
   end

   assign raw      = src_in | soft_q;
   assign irq_stat = raw & en_q & ~sel_q;
   assign fiq_stat = raw & en_q & sel_q;

endmodule

// File: rtl/vec_intc_slots.sv
module vec_intc_slots #(
   parameter  int NSRC   = 32,
   parameter  int NSLOT  = 16,
   parameter  int VEC_W  = 32,
   parameter  int LVL_W  = 5,
   localparam int SRC_W  = $clog2(NSRC),
   localparam int SLOT_W = $clog2(NSLOT),
   localparam int CTRL_W = SRC_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_addr,
   input  logic              wr_ctrl,
   input  logic [SLOT_W-1:0] idx,
   input  logic [31:0]       wdata,
   input  logic [NSRC-1:0]   irq_stat,
   input  logic [LVL_W-1:0]  cur_lvl,
   output logic [VEC_W-1:0]  rd_vaddr,
   output logic [CTRL_W-1:0] rd_ctrl,
   output logic [NSLOT-1:0]  grant,
   output logic              hit_any,
   output logic [SLOT_W-1:0] hit_idx,
   output logic [VEC_W-1:0]  hit_addr
);

   logic [VEC_W-1:0] vaddr_q [NSLOT];
   logic [SRC_W-1:0] src_q   [NSLOT];
   logic [NSLOT-1:0] on_q;
   logic [NSLOT-1:0] hit;

   for (genvar gk = 0; gk < NSLOT; gk++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vaddr_q[gk] <= '0;
            src_q[gk]   <= '0;
            on_q[gk]    <= 1'b0;
         end else begin
            if (wr_addr && (idx == SLOT_W'(gk))) vaddr_q[gk] <= wdata[VEC_W-1:0];
            if (wr_ctrl && (idx == SLOT_W'(gk))) begin
               src_q[gk] <= wdata[SRC_W-1:0];
               on_q[gk]  <= wdata[SRC_W];
            end
         end
      end
      // a slot competes only above the most urgent level already in service
      assign hit[gk] = on_q[gk] && irq_stat[src_q[gk]] && (LVL_W'(gk) < cur_lvl);
   end

   // isolate the lowest-numbered competing slot
   assign grant   = hit & (~hit + NSLOT'(1));
   assign hit_any = |hit;

   always_comb begin
      hit_idx  = '0;
      hit_addr = '0;
      for (int k = 0; k < NSLOT; k++) begin
         if (grant[k]) begin
            hit_idx  = hit_idx | SLOT_W'(k);
            hit_addr = hit_addr | vaddr_q[k];
         end
      end
   end

   assign rd_vaddr = vaddr_q[idx];
   assign rd_ctrl  = {on_q[idx], src_q[idx]};

endmodule

// File: rtl/vec_intc_nest.sv
module vec_intc_nest #(
   parameter  int NLEV  = 17,
   localparam int LVL_W = $clog2(NLEV + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [LVL_W-1:0] push_lvl,
   input  logic             pop,
   output logic [NLEV-1:0]  svc_q,
   output logic [LVL_W-1:0] cur_lvl,
   output logic             idle
);

   // pushes only ever add a more urgent level than any present, so the set of
   // in-service levels behaves as a stack whose top is its lowest set bit
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    svc_q <= '0;
      else if (push) svc_q <= svc_q | (NLEV'(1) << push_lvl);
      else if (pop)  svc_q <= svc_q & (svc_q - NLEV'(1));
   end

   always_comb begin
      cur_lvl = LVL_W'(NLEV);
      for (int k = NLEV - 1; k >= 0; k--) begin
         if (svc_q[k]) cur_lvl = LVL_W'(k);
      end
   end

   assign idle = (svc_q == '0);

endmodule

// File: rtl/vec_intc.sv
module vec_intc
   import vec_intc_pkg::*;
#(
   parameter int          NSRC    = 32,
   parameter int          NSLOT   = 16,
   parameter int          VEC_W   = 32,
   parameter logic [31:0] ID_WORD = 32'h0A1E_7C42
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            bus_en,
   input  logic            bus_we,
   input  logic [11:0]     bus_addr,
   input  logic [31:0]     bus_wdata,
   output logic [31:0]     bus_rdata,
   input  logic [NSRC-1:0] src_in,
   output logic            irq_o,
   output logic            fiq_o
);

   localparam int SRC_W  = $clog2(NSRC);
   localparam int SLOT_W = $clog2(NSLOT);
   localparam int CTRL_W = SRC_W + 1;
   localparam int NLEV   = NSLOT + 1;
   localparam int LVL_W  = $clog2(NLEV + 1);
   localparam int DEF_LV = NSLOT;

   if (NSRC < 2 || NSRC > BUS_DW || (1 << SRC_W) != NSRC) begin : g_bad_nsrc
      $error("NSRC must be a power of two between 2 and the bus width");
   end
   if (NSLOT < 2 || NSLOT > 64 || (1 << SLOT_W) != NSLOT) begin : g_bad_nslot
      $error("NSLOT must be a power of two between 2 and 64");
   end
   if (VEC_W < 1 || VEC_W > BUS_DW) begin : g_bad_vecw
      $error("VEC_W must lie between 1 and the bus width");
   end
   if (CTRL_W > BUS_DW) begin : g_bad_ctrl
      $error("slot control word does not fit the bus");
   end

   reg_sel_e          rsel;
   logic              wr_en, rd_vec, pop, push, slot_ok;
   logic [SLOT_W-1:0] slot_idx;

   assign rsel     = decode_reg(bus_addr);
   assign wr_en    = bus_en && bus_we;
   assign rd_vec   = bus_en && !bus_we && (rsel == RS_CUR_VEC);
   assign pop      = wr_en && (rsel == RS_CUR_VEC);
   assign slot_idx = bus_addr[SLOT_W+1:2];
   assign slot_ok  = ({2'b00, bus_addr[7:2]} < 8'(NSLOT));

   logic [NSRC-1:0] en_q, sel_q, soft_q, raw, irq_stat, fiq_stat;
   logic            prot_q;

   vec_intc_srcregs #(.NSRC(NSRC)) u_srcregs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .rsel     (rsel),
      .wdata    (bus_wdata[NSRC-1:0]),
      .prot_wbit(bus_wdata[0]),
      .src_in   (src_in),
      .en_q     (en_q),
      .sel_q    (sel_q),
      .soft_q   (soft_q),
      .prot_q   (prot_q),
      .raw      (raw),
      .irq_stat (irq_stat),
      .fiq_stat (fiq_stat)
   );

   logic [VEC_W-1:0] def_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              def_q <= '0;
      else if (wr_en && (rsel == RS_DEF_VEC))  def_q <= bus_wdata[VEC_W-1:0];
   end

   logic [NLEV-1:0]   svc_q;
   logic [LVL_W-1:0]  cur_lvl;
   logic              idle;
   logic [VEC_W-1:0]  rd_vaddr, hit_addr;
   logic [CTRL_W-1:0] rd_ctrl;
   logic [NSLOT-1:0]  slot_grant;
   logic              hit_any;
   logic [SLOT_W-1:0] hit_idx;

   vec_intc_slots #(
      .NSRC (NSRC),
      .NSLOT(NSLOT),
      .VEC_W(VEC_W),
      .LVL_W(LVL_W)
   ) u_slots (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_addr (wr_en && (rsel == RS_VADDR) && slot_ok),
      .wr_ctrl (wr_en && (rsel == RS_VCTRL) && slot_ok),
      .idx     (slot_idx),
      .wdata   (bus_wdata),
      .irq_stat(irq_stat),
      .cur_lvl (cur_lvl),
      .rd_vaddr(rd_vaddr),
      .rd_ctrl (rd_ctrl),
      .grant   (slot_grant),
      .hit_any (hit_any),
      .hit_idx (hit_idx),
      .hit_addr(hit_addr)
   );

   logic             dflt_entry;
   logic [LVL_W-1:0] push_lvl;
   logic [VEC_W-1:0] vec_out;

   // the default level enters service only from an empty stack
   assign dflt_entry = idle && (irq_stat != '0);
   assign push       = rd_vec && (hit_any || dflt_entry);
   assign push_lvl   = hit_any ? LVL_W'(hit_idx) : LVL_W'(DEF_LV);
   assign vec_out    = hit_any ? hit_addr : def_q;

   vec_intc_nest #(.NLEV(NLEV)) u_nest (
      .clk     (clk),
      .rst_n   (rst_n),
      .push    (push),
      .push_lvl(push_lvl),
      .pop     (pop),
      .svc_q   (svc_q),
      .cur_lvl (cur_lvl),
      .idle    (idle)
   );

   assign irq_o = hit_any || dflt_entry;
   assign fiq_o = (fiq_stat != '0);

   always_comb begin
      bus_rdata = '0;
      case (rsel)
         RS_IRQ_STAT: bus_rdata = 32'(irq_stat);
         RS_FIQ_STAT: bus_rdata = 32'(fiq_stat);
         RS_RAW_STAT: bus_rdata = 32'(raw);
         RS_ROUTE:    bus_rdata = 32'(sel_q);
         RS_EN_SET:   bus_rdata = 32'(en_q);
         RS_SW_SET:   bus_rdata = 32'(soft_q);
         RS_PROT:     bus_rdata = {31'b0, prot_q};
         RS_CUR_VEC:  bus_rdata = 32'(vec_out);
         RS_DEF_VEC:  bus_rdata = 32'(def_q);
         RS_VADDR:    if (slot_ok) bus_rdata = 32'(rd_vaddr);
         RS_VCTRL:    if (slot_ok) bus_rdata = 32'(rd_ctrl);
         RS_ID:       bus_rdata = {24'b0, ID_WORD[8*bus_addr[3:2] +: 8]};
         default:     bus_rdata = '0;
      endcase
   end

endmodule

// File: rtl/vec_intc_chk.sv
module vec_intc_chk #(
   parameter int NSRC  = 32,
   parameter int NSLOT = 16,
   parameter int NLEV  = 17
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_en,
   input logic             bus_we,
   input logic [11:0]      bus_addr,
   input logic [31:0]      bus_wdata,
   input logic             irq_o,
   input logic             fiq_o,
   input logic [NSRC-1:0]  en_q,
   input logic [NSRC-1:0]  sel_q,
   input logic [NLEV-1:0]  svc_q,
   input logic [NSLOT-1:0] grant
);

   logic vec_rd, vec_wr, en_set_wr, en_clr_wr;

   assign vec_rd    = bus_en && !bus_we && (bus_addr == 12'h030);
   assign vec_wr    = bus_en && bus_we && (bus_addr == 12'h030);
   assign en_set_wr = bus_en && bus_we && (bus_addr == 12'h010);
   assign en_clr_wr = bus_en && bus_we && (bus_addr == 12'h014);

   // R1
   reset_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (en_q == '0 && sel_q == '0 && svc_q == '0));

   // R8
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (svc_q == '0 && !vec_rd) |=> (svc_q == '0));

   // R8
   push_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vec_rd |=> ($countones(svc_q) <= $past($countones(svc_q)) + 1));

   // R9
   pop_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_wr && svc_q != '0) |=> ($countones(svc_q) == $past($countones(svc_q)) - 1));

   // R3
   en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en_set_wr |=> ((en_q & $past(bus_wdata[NSRC-1:0])) == $past(bus_wdata[NSRC-1:0])));

   // R3
   en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en_clr_wr |=> ((en_q & $past(bus_wdata[NSRC-1:0])) == '0));

   // R6
   fiq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fiq_o |-> ((en_q & sel_q) != '0));

   // R6
   irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> ((en_q & ~sel_q) != '0));

   // R7
   grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

endmodule

bind vec_intc vec_intc_chk #(
   .NSRC (NSRC),
   .NSLOT(NSLOT),
   .NLEV (NLEV)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_en   (bus_en),
   .bus_we   (bus_we),
   .bus_addr (bus_addr),
   .bus_wdata(bus_wdata),
   .irq_o    (irq_o),
   .fiq_o    (fiq_o),
   .en_q     (en_q),
   .sel_q    (sel_q),
   .svc_q    (svc_q),
   .grant    (slot_grant)
);

// File: tb/vec_intc_bench.sv
module vec_intc_bench;

   localparam int          CLK_PERIOD = 10;
   localparam logic [31:0] IDW        = 32'h0A1E_7C42;
   localparam logic [31:0] DEFV       = 32'h00EE_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_en = 1'b0;
   logic        bus_we = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] src_in = '0;
   logic        irq_o, fiq_o;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   vec_intc #(.NSRC(32), .NSLOT(16), .VEC_W(32), .ID_WORD(IDW)) u_vec_intc (
      .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .src_in(src_in), .irq_o(irq_o), .fiq_o(fiq_o)
   );

   function automatic logic [31:0] va(input int k);
      return 32'hC000_0000 + 32'(k) * 32'h104;
   endfunction

   function automatic logic [31:0] xs(input logic [31:0] x);
      logic [31:0] y;
      y = x ^ (x << 13);
      y = y ^ (y >> 17);
      y = y ^ (y << 5);
      return y;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      #1 bus_en = 1'b0; bus_we = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(posedge clk);
      #1 bus_en = 1'b0;
   endtask

   task automatic set_src(input logic [31:0] v);
      @(negedge clk);
      src_in = v;
      #1;
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      logic [31:0] d, m_en, m_sel, m_soft, m_src, rnd, a, raw_e, id_as;
      m_en = '0; m_sel = '0; m_soft = '0; m_src = '0; rnd = 32'h1234_5678;

      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: reset state
      chk("R1 irq", 32'(irq_o), 0);
      chk("R1 fiq", 32'(fiq_o), 0);
      for (int o = 0; o <= 'h34; o += 4) begin
         rd(12'(o), d);
         chk("R1 reg", d, 0);
      end
      rd(12'h200, d); chk("R1 slot ctrl", d, 0);

      // R11: identification bytes and vendor code
      id_as = '0;
      for (int i = 0; i < 4; i++) begin
         rd(12'hFE0 + 12'(4 * i), d);
         chk("R11 id byte", d, 32'(IDW[8*i +: 8]));
         id_as = id_as | ((d & 32'hFF) << (8 * i));
      end
      chk("R11 vendor", (id_as >> 12) & 32'hFF, (IDW >> 12) & 32'hFF);

      // R2 R3 R4 R5 R6: sweep of mask operations with no slots enabled
      for (int it = 0; it < 48; it++) begin
         rnd = xs(rnd); wr(12'h010, rnd); m_en = m_en | rnd;
         rnd = xs(rnd); a = rnd & xs(rnd ^ 32'h55AA); wr(12'h014, a); m_en = m_en & ~a;
         rnd = xs(rnd); a = rnd & 32'h0F0F_3C3C; wr(12'h018, a); m_soft = m_soft | a;
         rnd = xs(rnd); a = rnd & 32'h3030_FF00; wr(12'h01C, a); m_soft = m_soft & ~a;
         rnd = xs(rnd); wr(12'h00C, rnd); m_sel = rnd;
         rnd = xs(rnd); m_src = (it % 8 == 0) ? 32'h0 : rnd; set_src(m_src);
         raw_e = m_src | m_soft;
         rd(12'h008, d); chk("R2 raw", d, raw_e);
         rd(12'h010, d); chk("R3 enable", d, m_en);
         rd(12'h018, d); chk("R4 soft", d, m_soft);
         rd(12'h00C, d); chk("R5 route", d, m_sel);
         rd(12'h000, d); chk("R5 irq status", d, raw_e & m_en & ~m_sel);
         rd(12'h004, d); chk("R5 fiq status", d, raw_e & m_en & m_sel);
         chk("R6 irq line", 32'(irq_o), 32'((raw_e & m_en & ~m_sel) != 0));
         chk("R6 fiq line", 32'(fiq_o), 32'((raw_e & m_en & m_sel) != 0));
      end
      // R2: status addresses ignore writes
      wr(12'h000, 32'hFFFF_FFFF); wr(12'h004, 32'hFFFF_FFFF); wr(12'h008, 32'h0);
      rd(12'h008, d); chk("R2 status write ignored", d, m_src | m_soft);
      rd(12'h010, d); chk("R2 enable untouched", d, m_en);

      // clean up masks
      wr(12'h014, 32'hFFFF_FFFF); wr(12'h01C, 32'hFFFF_FFFF); wr(12'h00C, 32'h0);
      set_src(32'h0);

      // R12: slot, default and protection readback
      for (int k = 0; k < 16; k++) begin
         wr(12'h100 + 12'(4 * k), va(k));
         wr(12'h200 + 12'(4 * k), 32'hFFFF_FFC0 | 32'h20 | 32'(2 * k + 1));
      end
      wr(12'h034, DEFV);
      wr(12'h020, 32'h0000_0003);
      for (int k = 0; k < 16; k++) begin
         rd(12'h100 + 12'(4 * k), d); chk("R12 slot addr", d, va(k));
         rd(12'h200 + 12'(4 * k), d); chk("R12 slot ctrl", d, 32'h20 | 32'(2 * k + 1));
      end
      rd(12'h034, d); chk("R12 default", d, DEFV);
      rd(12'h020, d); chk("R12 protect", d, 1);

      // R7: vector selection, two slots active and the lower number wins
      wr(12'h010, 32'hFFFF_FFFF);
      for (int k = 0; k < 16; k++) begin
         m_src = 32'(1) << (2 * k + 1);
         if (k < 15) m_src = m_src | (32'(1) << (2 * k + 3));
         set_src(m_src);
         chk("R7 irq line", 32'(irq_o), 1);
         rd(12'h030, d); chk("R7 vector", d, va(k));
         wr(12'h030, 32'h0);
      end
      // R7: source bound to no slot gives default
      set_src(32'h0000_0001);
      rd(12'h030, d); chk("R7 default vector", d, DEFV);
      wr(12'h030, 32'h0);
      // R5 R7: a source routed to the fast line takes no vector
      wr(12'h00C, 32'h0000_0080);
      set_src(32'h0000_0080);
      chk("R5 routed irq", 32'(irq_o), 0);
      chk("R5 routed fiq", 32'(fiq_o), 1);
      rd(12'h030, d); chk("R7 routed vector", d, DEFV);
      chk("R8 no push when idle and quiet", 32'(irq_o), 0);
      wr(12'h00C, 32'h0);
      // R7: disabled slot falls to default
      wr(12'h200 + 12'(4 * 4), 32'(9));
      set_src(32'h0000_0200);
      rd(12'h030, d); chk("R7 disabled slot", d, DEFV);
      wr(12'h030, 32'h0);
      wr(12'h200 + 12'(4 * 4), 32'h20 | 32'(9));

      // R8 R9: nesting
      set_src(32'(1) << 11);                      // slot 5
      rd(12'h030, d); chk("R8 enter slot 5", d, va(5));
      set_src((32'(1) << 11) | (32'(1) << 19));    // add slot 9
      chk("R8 lower priority blocked", 32'(irq_o), 0);
      rd(12'h030, d); chk("R8 blocked vector", d, DEFV);
      set_src((32'(1) << 11) | (32'(1) << 19) | (32'(1) << 5)); // add slot 2
      chk("R8 higher priority preempts", 32'(irq_o), 1);
      rd(12'h030, d); chk("R8 enter slot 2", d, va(2));
      chk("R8 slot 2 in service", 32'(irq_o), 0);
      wr(12'h030, 32'hDEAD_BEEF);
      chk("R9 back at slot 5", 32'(irq_o), 1);
      set_src((32'(1) << 11) | (32'(1) << 19));
      chk("R9 slot 5 blocks itself", 32'(irq_o), 0);
      wr(12'h030, 32'h0);
      chk("R9 empty again", 32'(irq_o), 1);
      rd(12'h030, d); chk("R9 vector after unwind", d, va(5));
      wr(12'h030, 32'h0);
      // R8: default level blocks unvectored but not slots
      set_src(32'h0000_0001);
      rd(12'h030, d); chk("R8 enter default", d, DEFV);
      chk("R8 default in service", 32'(irq_o), 0);
      set_src(32'h0000_0001 | (32'(1) << 7));      // slot 3
      chk("R8 slot over default", 32'(irq_o), 1);
      wr(12'h030, 32'h0);
      set_src(32'h0);

      // R10: fill every level, then unwind with enables cleared
      set_src(32'h0000_0001);
      rd(12'h030, d);
      m_src = 32'h0000_0001;
      for (int k = 15; k >= 0; k--) begin
         m_src = m_src | (32'(1) << (2 * k + 1));
         set_src(m_src);
         rd(12'h030, d);
         chk("R10 fill", d, va(k));
      end
      wr(12'h014, 32'hFFFF_FFFF);
      wr(12'h030, 32'h0);
      for (int p = 0; p < 14; p++) begin
         rd(12'h030, d); wr(12'h030, d);
      end
      wr(12'h010, 32'h8000_0000);
      chk("R10 partial unwind still nested", 32'(irq_o), 0);
      wr(12'h014, 32'hFFFF_FFFF);
      for (int p = 0; p < 5; p++) begin
         rd(12'h030, d); wr(12'h030, d);
      end
      wr(12'h010, 32'h8000_0000);
      chk("R10 unwound irq", 32'(irq_o), 1);
      rd(12'h030, d); chk("R10 unwound vector", d, va(15));
      wr(12'h030, 32'h0);

      // R1: reset again clears programmed state
      @(negedge clk) rst_n = 1'b0;
      @(negedge clk) rst_n = 1'b1;
      rd(12'h010, d); chk("R1 enable after reset", d, 0);
      rd(12'h030, d); chk("R1 vector after reset", d, 0);
      rd(12'h204, d); chk("R1 slot after reset", d, 0);

      finish_run();
   end

endmodule